// File: doc/BRIEF.md
# Write-Completion Polling Engine

This engine sits on the host side of a parallel flash. After software or another controller has issued a program or erase command, the engine is started with the target address, the byte the location should finally hold, and a choice between two status methods. It then keeps reading that address over a simple read request/response bus until the part reports the internal write as finished.

Two status methods are offered. In data-bit mode the engine waits for bit 7 of the returned byte to match bit 7 of the expected byte; during an erase the expected byte is all ones. In toggle mode it waits for bit 6 to stop changing between successive reads. Completion happens asynchronously, so a status read can land on the exact moment the write ends and show a misleading byte. Once a status read first looks complete, the engine waits a settle interval and then takes two more full-byte reads. Only if both return the expected byte does it pulse `done`. A mismatch, or too many unsuccessful status reads, pulses `fail`.

Top module: `wcp_engine`

## Requirements
- R1: While and right after reset, `done`, `fail`, `rd_req` and `busy` are all low.
- R2: `start` is taken only while the engine is idle, and `mode` (0 = data-bit, 1 = toggle), `tgt_addr` and `exp_data` are latched at that edge. A `start` seen while busy changes neither the address read nor the result.
- R3: In data-bit mode (`mode` = 0) a status read is satisfied when its bit 7 equals bit 7 of `exp_data`. Erase completion is polled with `exp_data` = 8'hFF.
- R4: In toggle mode (`mode` = 1) a status read is satisfied when its bit 6 equals bit 6 of the previous status read of the same operation. The first status read of an operation never satisfies.
- R5: `rd_req` for the first confirmation read rises at the (SETTLE_CYC+1)-th clock edge after the edge that captures the satisfying status response.
- R6: After a satisfied status read the engine issues exactly two confirmation reads. `done` is pulsed only if both return a byte equal to `exp_data` in all bits.
- R7: If a confirmation read differs from `exp_data`, `fail` is pulsed and no further read is issued for that operation.
- R8: After MAX_POLLS unsatisfied status reads, `fail` is pulsed; exactly MAX_POLLS reads have then been issued.
- R9: `done` and `fail` are single-cycle pulses, never high together, and exactly one of them follows each accepted `start`.
- R10: `rd_req` is a one-cycle pulse, at most one read is outstanding, every request carries the latched address, and `busy` falls the cycle after the final pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| mode | input | 1 | Status method: 0 data-bit, 1 toggle |
| tgt_addr | input | AW | Location to poll |
| exp_data | input | DW | Byte the location must finally hold |
| busy | output | 1 | An operation is in progress |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Address of the read request |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DW | Read response byte |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The bench builds the engine with SETTLE_CYC = 5 and MAX_POLLS = 8 instead of the hardware-sized defaults. The short settle window lets the exact request spacing after a satisfying read be measured within a few cycles. The small poll limit lets both the data-bit and the toggle timeout be driven to the error path with an eight-entry response script. A bus model answers each request two cycles later from a per-scenario byte list, so every read count and outcome follows directly from the listed bytes.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

  typedef enum logic [0:0] {
    CHK_DATA   = 1'b0,
    CHK_TOGGLE = 1'b1
  } chk_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_EVAL,
    ST_SETTLE,
    ST_CONF1,
    ST_CONF2,
    ST_DONE,
    ST_ERR
  } wcp_state_e;

  localparam int unsigned POLARITY_BIT = 7;
  localparam int unsigned TOGGLE_BIT   = 6;

  function automatic logic is_read_state(wcp_state_e s);
    return (s == ST_POLL) || (s == ST_CONF1) || (s == ST_CONF2);
  endfunction

endpackage

// File: rtl/wcp_read_port.sv
module wcp_read_port #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic [AW-1:0] issue_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data
);

  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
      waiting <= 1'b0;
    end else begin
      rd_req <= issue;
      if (issue) begin
        rd_addr <= issue_addr;
        waiting <= 1'b1;
      end else if (rd_valid && waiting) begin
        waiting <= 1'b0;
      end
    end
  end

  assign resp_valid = rd_valid && waiting;
  assign resp_data  = rd_data;

  // R10: a new request is never issued while one is outstanding
  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    issue |-> !waiting || resp_valid);

endmodule

// File: rtl/wcp_settle_timer.sv
module wcp_settle_timer #(
  parameter int unsigned CYC = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int unsigned TW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [TW-1:0] LOADV = TW'((CYC > 0) ? CYC - 1 : 0);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOADV;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R5: the window is reloaded to its full length on every start
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == LOADV));

endmodule

// File: rtl/wcp_status_judge.sv
module wcp_status_judge
  import wcp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  chk_mode_e     mode,
  input  logic [DW-1:0] expect_v,
  input  logic          update,
  input  logic [DW-1:0] poll_v,
  input  logic [DW-1:0] conf_v,
  output logic          poll_hit,
  output logic          conf_ok
);

  logic prev_tog;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_tog <= 1'b0;
      seen     <= 1'b0;
    end else if (update) begin
      prev_tog <= poll_v[TOGGLE_BIT];
      seen     <= 1'b1;
    end
  end

  always_comb begin
    if (mode == CHK_DATA) begin
      poll_hit = (poll_v[POLARITY_BIT] == expect_v[POLARITY_BIT]);
    end else begin
      poll_hit = seen && (poll_v[TOGGLE_BIT] == prev_tog);
    end
  end

  assign conf_ok = (conf_v == expect_v);

endmodule

// File: rtl/wcp_engine.sv
module wcp_engine
  import wcp_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned SETTLE_CYC = 250,
  parameter int unsigned MAX_POLLS  = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] exp_data,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic          fail
);

  localparam int unsigned PCW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [PCW-1:0] LAST_POLL = PCW'(MAX_POLLS - 1);

  wcp_state_e state, state_n;
  chk_mode_e  mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic [DW-1:0] data_q;
  logic [PCW-1:0] poll_cnt;

  logic accept;
  logic issue;
  logic resp_valid;
  logic [DW-1:0] resp_data;
  logic poll_hit, conf_ok;
  logic settle_load, settle_done;

  assign accept = (state == ST_IDLE) && start;

  always_comb begin
    state_n = state;
    case (state)
      ST_IDLE:   if (start) state_n = ST_POLL;
      ST_POLL:   if (resp_valid) state_n = ST_EVAL;
      ST_EVAL: begin
        if (poll_hit) begin
          state_n = (SETTLE_CYC == 0) ? ST_CONF1 : ST_SETTLE;
        end else if (poll_cnt == LAST_POLL) begin
          state_n = ST_ERR;
        end else begin
          state_n = ST_POLL;
        end
      end
      ST_SETTLE: if (settle_done) state_n = ST_CONF1;
      ST_CONF1:  if (resp_valid) state_n = conf_ok ? ST_CONF2 : ST_ERR;
      ST_CONF2:  if (resp_valid) state_n = conf_ok ? ST_DONE : ST_ERR;
      ST_DONE:   state_n = ST_IDLE;
      ST_ERR:    state_n = ST_IDLE;
      default:   state_n = ST_IDLE;
    endcase
  end

  assign issue       = is_read_state(state_n) && (state_n != state);
  assign settle_load = (state == ST_EVAL) && (state_n == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= CHK_DATA;
      addr_q   <= '0;
      exp_q    <= '0;
      data_q   <= '0;
      poll_cnt <= '0;
    end else begin
      state <= state_n;
      if (accept) begin
        mode_q   <= chk_mode_e'(mode);
        addr_q   <= tgt_addr;
        exp_q    <= exp_data;
        poll_cnt <= '0;
      end
      if ((state == ST_POLL) && resp_valid) begin
        data_q <= resp_data;
      end
      if ((state == ST_EVAL) && !poll_hit && (poll_cnt != LAST_POLL)) begin
        poll_cnt <= poll_cnt + 1'b1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
  assign fail = (state == ST_ERR);

  wcp_read_port #(.AW(AW), .DW(DW)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_addr (accept ? tgt_addr : addr_q),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .resp_valid (resp_valid),
    .resp_data  (resp_data)
  );

  wcp_status_judge #(.DW(DW)) u_judge (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .mode     (mode_q),
    .expect_v (exp_q),
    .update   (state == ST_EVAL),
    .poll_v   (data_q),
    .conf_v   (resp_data),
    .poll_hit (poll_hit),
    .conf_ok  (conf_ok)
  );

  wcp_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .load    (settle_load),
    .expired (settle_done)
  );

  // R9: outcome pulses
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r9_fail_pulse: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);

  // R10: request strobe and address stability
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd_addr));

  // R2: a start while busy leaves the latched operation untouched
  a_r2_no_restart: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(addr_q) && $stable(exp_q) && $stable(mode_q)));

  // R4: first toggle-mode status read cannot end polling
  a_r4_first_toggle: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_EVAL) && (mode_q == CHK_TOGGLE) && (poll_cnt == '0))
      |=> (state != ST_SETTLE) && (state != ST_CONF1));

  // R7: no read follows a failure
  a_r7_quiet_after_fail: assert property (@(posedge clk) disable iff (rst)
    fail |-> !rd_req);

endmodule

// File: tb/wcp_engine_tb.sv
module wcp_engine_tb;

  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int SC  = 5;
  localparam int MP  = 8;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [AW-1:0] tgt_addr = '0;
  logic [DW-1:0] exp_data = '0;
  logic busy, rd_req, done, fail;
  logic [AW-1:0] rd_addr;
  logic rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [7:0] resp [0:31];
  int req_cyc [0:31];
  int resp_cyc [0:31];
  int n_req = 0;
  int n_resp = 0;
  int bad_addr = 0;
  logic [AW-1:0] cur_addr = '0;
  int cnt = 0;

  always #2 clk = ~clk;

  wcp_engine #(.AW(AW), .DW(DW), .SETTLE_CYC(SC), .MAX_POLLS(MP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .tgt_addr(tgt_addr),
    .exp_data(exp_data), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .fail(fail)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // bus model: answers each request LAT cycles later from resp[]
  initial begin
    forever begin
      @(posedge clk); #1;
      rd_valid = 1'b0;
      if (rd_req) begin
        if (n_req < 32) req_cyc[n_req] = cyc;
        n_req++;
        if (rd_addr !== cur_addr) bad_addr++;
        cnt = LAT;
      end else if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rd_valid = 1'b1;
          rd_data  = (n_resp < 32) ? resp[n_resp] : 8'h00;
          if (n_resp < 32) resp_cyc[n_resp] = cyc;
          n_resp++;
        end
      end
    end
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish (act=hung exp=finished)");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic load_resp(input logic [7:0] v [0:7], input int n);
    for (int i = 0; i < 32; i++) resp[i] = 8'h00;
    for (int i = 0; i < n; i++) resp[i] = v[i];
    n_req = 0; n_resp = 0; bad_addr = 0; cnt = 0;
  endtask

  // runs one operation; optionally pokes start again while busy
  task automatic run_op(input logic m, input logic [AW-1:0] a, input logic [DW-1:0] e,
                        input bit poke, output int nd, output int nf, output bit busy_low);
    int k;
    nd = 0; nf = 0;
    cur_addr = a;
    @(posedge clk); #1;
    start = 1'b1; mode = m; tgt_addr = a; exp_data = e;
    @(posedge clk); #1;
    start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1; start = 1'b1; mode = ~m; tgt_addr = 16'h9999; exp_data = ~e;
      @(posedge clk); #1; start = 1'b0;
    end
    k = 0;
    while (!(done || fail) && k < 500) begin
      @(posedge clk); #1; k++;
    end
    if (done) nd++;
    if (fail) nf++;
    @(posedge clk); #1;
    busy_low = !busy;
    for (int i = 0; i < 4; i++) begin
      if (done) nd++;
      if (fail) nf++;
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset();
    chk(!done && !fail && !rd_req && !busy, "R1 reset outputs", {done, fail, rd_req, busy}, 0);
  endtask

  task automatic t_data_program();
    logic [7:0] v [0:7] = '{8'h25, 8'h25, 8'hA5, 8'hA5, 8'hA5, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 5);
    run_op(1'b0, 16'h1234, 8'hA5, 1'b0, nd, nf, bl);
    chk(nd == 1 && nf == 0, "R3 data-bit program done", nd, 1);
    chk(n_req == 5, "R6 data-bit read count", n_req, 5);
    chk(req_cyc[3] - resp_cyc[2] == SC + 2, "R5 settle spacing", req_cyc[3] - resp_cyc[2], SC + 2);
    chk(bl, "R10 busy low after pulse", bl, 1);
    chk(bad_addr == 0, "R10 request address", bad_addr, 0);
  endtask

  task automatic t_data_erase();
    logic [7:0] v [0:7] = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 4);
    run_op(1'b0, 16'h0040, 8'hFF, 1'b0, nd, nf, bl);
    chk(nd == 1 && nf == 0, "R3 erase done", nd, 1);
    chk(n_req == 4, "R3 erase read count", n_req, 4);
  endtask

  task automatic t_race_conf1();
    logic [7:0] v [0:7] = '{8'h85, 8'h05, 8'hA5, 8'hA5, 0, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 4);
    run_op(1'b0, 16'h0777, 8'hA5, 1'b0, nd, nf, bl);
    chk(nf == 1 && nd == 0, "R7 first confirm mismatch fails", nf, 1);
    chk(n_req == 2, "R7 no read after failure", n_req, 2);
  endtask

  task automatic t_race_conf2();
    logic [7:0] v [0:7] = '{8'hA5, 8'hA5, 8'hA4, 8'hA5, 0, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 4);
    run_op(1'b0, 16'h0778, 8'hA5, 1'b0, nd, nf, bl);
    chk(nf == 1 && nd == 0, "R6 second confirm mismatch fails", nf, 1);
    chk(n_req == 3, "R7 read count at second confirm", n_req, 3);
  endtask

  task automatic t_toggle_ok();
    logic [7:0] v [0:7] = '{8'h00, 8'h40, 8'h4A, 8'h4A, 8'h4A, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 5);
    run_op(1'b1, 16'h2000, 8'h4A, 1'b0, nd, nf, bl);
    chk(nd == 1 && nf == 0, "R4 toggle done", nd, 1);
    chk(n_req == 5, "R4 toggle read count", n_req, 5);
  endtask

  task automatic t_toggle_first();
    logic [7:0] v [0:7] = '{8'h4A, 8'h4A, 8'h4A, 8'h4A, 8'h4A, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 5);
    run_op(1'b1, 16'h2001, 8'h4A, 1'b0, nd, nf, bl);
    chk(nd == 1, "R4 toggle steady done", nd, 1);
    chk(n_req == 4, "R4 first read never satisfies", n_req, 4);
  endtask

  task automatic t_timeout_data();
    logic [7:0] v [0:7] = '{0, 0, 0, 0, 0, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 8);
    run_op(1'b0, 16'h3000, 8'h80, 1'b0, nd, nf, bl);
    chk(nf == 1 && nd == 0, "R8 data-bit timeout fails", nf, 1);
    chk(n_req == MP, "R8 data-bit timeout read count", n_req, MP);
  endtask

  task automatic t_timeout_toggle();
    logic [7:0] v [0:7] = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    int nd, nf; bit bl;
    load_resp(v, 8);
    run_op(1'b1, 16'h3001, 8'h40, 1'b0, nd, nf, bl);
    chk(nf == 1 && nd == 0, "R8 toggle timeout fails", nf, 1);
    chk(n_req == MP, "R8 toggle timeout read count", n_req, MP);
  endtask

  task automatic t_busy_start();
    logic [7:0] v [0:7] = '{8'h25, 8'h25, 8'hA5, 8'hA5, 8'hA5, 0, 0, 0};
    int nd, nf; bit bl;
    load_resp(v, 5);
    run_op(1'b0, 16'h4321, 8'hA5, 1'b1, nd, nf, bl);
    chk(bad_addr == 0, "R2 start while busy ignored (address)", bad_addr, 0);
    chk(nd == 1 && nf == 0, "R2 start while busy ignored (result)", nd, 1);
    chk(n_req == 5, "R2 start while busy ignored (reads)", n_req, 5);
    chk(nd + nf == 1, "R9 one outcome pulse", nd + nf, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    @(posedge clk); #1;
    t_reset();
    t_data_program();
    t_data_erase();
    t_race_conf1();
    t_race_conf2();
    t_toggle_ok();
    t_toggle_first();
    t_timeout_data();
    t_timeout_toggle();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule